// File: doc/BRIEF.md
# Coprocessor TLB-Maintenance Trap Decoder

This block sits beside the instruction decode of a processor core that runs a 32-bit state at its kernel level. It looks at one coprocessor-space move whose encoding names a last-level, inner-shareable TLB invalidate by address. It decides what happens to that move:

- the move is not this instruction at all;
- the move is undefined;
- the move is trapped to the hypervisor, in either the 64-bit or the 32-bit trap form;
- the move executes against a chosen translation regime.

The invalidation itself is carried out elsewhere.

A request is presented with a one-cycle decode strobe. The verdict appears on registered outputs exactly one cycle later, together with a result-valid pulse. The verdict carries:

- a result code;
- an 8-bit exception syndrome class;
- the selected regime;
- which hypervisor trap control fired.

There is no back-pressure. Every strobe produces exactly one verdict on the following cycle, and the consumer must take it then. While result-valid is low, all verdict fields read zero.

Top module: `cp_maint_gatekeeper`

## Requirements
- R1: The move is recognised only when cp_num=15, op_hi=0, cr_major=8, cr_minor=3 and op_lo=5. Any other encoding gives res_code 0 (not this instruction), with syndrome, regime and cause all 0.
- R2: A recognised move with feat_k32=0 gives res_code 1 (undefined) at every level.
- R3: A recognised move at cur_level 0 (user) gives res_code 1 (undefined), whatever the hypervisor controls are.
- R4: At cur_level 1 (kernel) with hyp_on=1, the trap controls are taken in a fixed priority order: trap_ctl[0] (register-group trap) first, then trap_ctl[1] (all TLB maintenance), then trap_ctl[2] (inner-shareable TLB maintenance). res_cause holds the winning bit index plus one, and 0 when no trap is taken.
- R5: A trap gives res_code 2 when hyp_is64=1 and res_code 3 when hyp_is64=0. Every trap reports res_syn 0x03, and every non-trap verdict reports res_syn 0.
- R6: At cur_level 1, when hyp_on=0 or no trap control is set, the move executes: res_code 4 with res_regime 1 (guest regime).
- R7: At cur_level 2 (hypervisor) the move always executes with res_regime 1, ignoring the trap controls. At cur_level 3 (monitor) it executes with res_regime 2 (own regime). Non-executing verdicts give res_regime 0.
- R8: res_vld is high exactly in the cycle after a cycle with dec_stb high. The verdict fields are zero whenever res_vld is low, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_stb | input | 1 | Decode strobe, one verdict per high cycle |
| cp_num | input | 4 | Coprocessor number field |
| op_hi | input | 3 | First opcode field |
| cr_major | input | 4 | Primary coprocessor register field |
| cr_minor | input | 4 | Secondary coprocessor register field |
| op_lo | input | 3 | Second opcode field |
| cur_level | input | 2 | Current exception level, 0 user to 3 monitor |
| feat_k32 | input | 1 | 32-bit kernel-level support present |
| hyp_on | input | 1 | Hypervisor level enabled |
| hyp_is64 | input | 1 | Hypervisor runs the 64-bit state |
| trap_ctl | input | 3 | Hypervisor trap controls, bit 0 highest priority |
| res_vld | output | 1 | Verdict valid, one cycle after the strobe |
| res_code | output | 3 | 0 no match, 1 undefined, 2 trap 64-bit, 3 trap 32-bit, 4 execute |
| res_syn | output | 8 | Exception syndrome class |
| res_regime | output | 2 | 0 none, 1 guest, 2 own (monitor) |
| res_cause | output | 2 | Winning trap control index plus one, 0 if none |

## Verification
The assertions assume that the decode fields, level and control inputs are stable and known in any cycle where dec_stb is high. They also assume that those inputs change only between clock edges. The assertions make no assumption about strobe spacing, since the block accepts a strobe every cycle. The stimulus drives every input on the falling edge, so nothing moves near the capturing edge. It first sweeps all levels, all trap-control patterns and both hypervisor states against the recognised encoding. It then applies random strobes, mostly recognised encodings with occasional single-field corruptions, and leaves gaps between strobes to exercise the idle-zero rule.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int SYN_W    = 8;
  localparam int TRAP_CNT = 3;
  localparam int CAUSE_W  = $clog2(TRAP_CNT + 1);

  typedef enum logic [2:0] {
    RC_NONE   = 3'd0,
    RC_UNDEF  = 3'd1,
    RC_TRAP_W = 3'd2,
    RC_TRAP_N = 3'd3,
    RC_EXEC   = 3'd4
  } rcode_e;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_GUEST = 2'd1,
    RG_OWN   = 2'd2
  } regime_e;

  typedef enum logic [1:0] {
    LV_USER   = 2'd0,
    LV_KERNEL = 2'd1,
    LV_HYP    = 2'd2,
    LV_MON    = 2'd3
  } level_e;

  typedef struct packed {
    rcode_e             code;
    logic [SYN_W-1:0]   syn;
    regime_e            regime;
    logic [CAUSE_W-1:0] cause;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{code: RC_NONE, syn: '0, regime: RG_NONE, cause: '0};
endpackage

// File: rtl/cpg_match.sv
module cpg_match #(
  parameter int CP_W  = 4,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [CP_W-1:0]  CP_VAL  = 4'd15,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'd0,
  parameter logic [CRN_W-1:0] CRN_VAL = 4'd8,
  parameter logic [CRM_W-1:0] CRM_VAL = 4'd3,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'd5
) (
  input  logic [CP_W-1:0]  cp_num,
  input  logic [OP1_W-1:0] op_hi,
  input  logic [CRN_W-1:0] cr_major,
  input  logic [CRM_W-1:0] cr_minor,
  input  logic [OP2_W-1:0] op_lo,
  output logic             hit
);
  localparam int FIELDS = 5;
  logic [FIELDS-1:0] eq;

  always_comb begin
    eq[0] = (cp_num   == CP_VAL);
    eq[1] = (op_hi    == OP1_VAL);
    eq[2] = (cr_major == CRN_VAL);
    eq[3] = (cr_minor == CRM_VAL);
    eq[4] = (op_lo    == OP2_VAL);
  end

  assign hit = &eq;
endmodule

// File: rtl/cpg_prio.sv
module cpg_prio #(
  parameter int N  = 3,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx1
);
  logic [N:0]   seen;
  logic [N-1:0] win;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign win[g]      = req[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | req[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx1 = '0;
    for (int k = 0; k < N; k++) begin
      if (win[k]) idx1 = idx1 | IW'(k + 1);
    end
  end
endmodule

// File: rtl/cpg_judge.sv
module cpg_judge
  import cpg_pkg::*;
#(
  parameter logic [SYN_W-1:0] TRAP_SYN = 8'h03
) (
  input  logic               hit,
  input  logic               feat_k32,
  input  logic [1:0]         cur_level,
  input  logic               hyp_on,
  input  logic               hyp_is64,
  input  logic               trap_any,
  input  logic [CAUSE_W-1:0] trap_idx1,
  output verdict_t           verdict
);
  level_e lvl;
  assign lvl = level_e'(cur_level);

  always_comb begin
    verdict = VERDICT_IDLE;
    if (hit) begin
      if (!feat_k32) begin
        verdict.code = RC_UNDEF;
      end else begin
        unique case (lvl)
          LV_USER: verdict.code = RC_UNDEF;
          LV_KERNEL: begin
            if (hyp_on && trap_any) begin
              verdict.code  = hyp_is64 ? RC_TRAP_W : RC_TRAP_N;
              verdict.syn   = TRAP_SYN;
              verdict.cause = trap_idx1;
            end else begin
              verdict.code   = RC_EXEC;
              verdict.regime = RG_GUEST;
            end
          end
          LV_HYP: begin
            verdict.code   = RC_EXEC;
            verdict.regime = RG_GUEST;
          end
          LV_MON: begin
            verdict.code   = RC_EXEC;
            verdict.regime = RG_OWN;
          end
          default: verdict = VERDICT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpg_outreg.sv
module cpg_outreg
  import cpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stb,
  input  verdict_t d,
  output logic     vld,
  output verdict_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= VERDICT_IDLE;
    end else begin
      vld <= stb;
      q   <= stb ? d : VERDICT_IDLE;
    end
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (q == VERDICT_IDLE));

  assert_trap_syn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (q.code == RC_TRAP_W || q.code == RC_TRAP_N)) |-> (q.syn == 8'h03));

  assert_exec_regime_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && q.code != RC_EXEC) |-> (q.regime == RG_NONE));
endmodule

// File: rtl/cp_maint_gatekeeper.sv
module cp_maint_gatekeeper
  import cpg_pkg::*;
#(
  parameter int CP_W  = 4,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [SYN_W-1:0] TRAP_SYN = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_stb,
  input  logic [CP_W-1:0]    cp_num,
  input  logic [OP1_W-1:0]   op_hi,
  input  logic [CRN_W-1:0]   cr_major,
  input  logic [CRM_W-1:0]   cr_minor,
  input  logic [OP2_W-1:0]   op_lo,
  input  logic [1:0]         cur_level,
  input  logic               feat_k32,
  input  logic               hyp_on,
  input  logic               hyp_is64,
  input  logic [TRAP_CNT-1:0] trap_ctl,
  output logic               res_vld,
  output logic [2:0]         res_code,
  output logic [SYN_W-1:0]   res_syn,
  output logic [1:0]         res_regime,
  output logic [CAUSE_W-1:0] res_cause
);
  logic               hit;
  logic               trap_any;
  logic [CAUSE_W-1:0] trap_idx1;
  verdict_t           verdict_d;
  verdict_t           verdict_q;

  cpg_match #(
    .CP_W(CP_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
  ) u_match (
    .cp_num(cp_num), .op_hi(op_hi), .cr_major(cr_major),
    .cr_minor(cr_minor), .op_lo(op_lo), .hit(hit)
  );

  cpg_prio #(.N(TRAP_CNT), .IW(CAUSE_W)) u_prio (
    .req(trap_ctl), .any(trap_any), .idx1(trap_idx1)
  );

  cpg_judge #(.TRAP_SYN(TRAP_SYN)) u_judge (
    .hit(hit), .feat_k32(feat_k32), .cur_level(cur_level),
    .hyp_on(hyp_on), .hyp_is64(hyp_is64),
    .trap_any(trap_any), .trap_idx1(trap_idx1), .verdict(verdict_d)
  );

  cpg_outreg u_out (
    .clk(clk), .rst_n(rst_n), .stb(dec_stb), .d(verdict_d),
    .vld(res_vld), .q(verdict_q)
  );

  assign res_code   = verdict_q.code;
  assign res_syn    = verdict_q.syn;
  assign res_regime = verdict_q.regime;
  assign res_cause  = verdict_q.cause;

  assert_stb_to_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> res_vld);

  assert_nostb_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_stb |=> !res_vld);

  assert_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && !hit) |=> (res_code == 3'd0));

  assert_nofeat_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && !feat_k32) |=> (res_code == 3'd1));

  assert_user_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && cur_level == 2'd0) |=> (res_code == 3'd1));

  assert_first_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && feat_k32 && cur_level == 2'd1 && hyp_on && trap_ctl[0])
    |=> (res_cause == CAUSE_W'(1)));

  assert_trap_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && feat_k32 && cur_level == 2'd1 && hyp_on && (|trap_ctl))
    |=> (res_code == ($past(hyp_is64) ? 3'd2 : 3'd3)));

  assert_kernel_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && feat_k32 && cur_level == 2'd1 && !hyp_on)
    |=> (res_code == 3'd4 && res_regime == 2'd1));

  assert_hyp_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stb && hit && feat_k32 && cur_level == 2'd2)
    |=> (res_code == 3'd4 && res_regime == 2'd1));
endmodule

// File: tb/sim_cp_maint_gatekeeper.sv
`timescale 1ns/1ps
module sim_cp_maint_gatekeeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_stb = 1'b0;
  logic [3:0] cp_num = '0;
  logic [2:0] op_hi = '0;
  logic [3:0] cr_major = '0;
  logic [3:0] cr_minor = '0;
  logic [2:0] op_lo = '0;
  logic [1:0] cur_level = '0;
  logic       feat_k32 = 1'b0;
  logic       hyp_on = 1'b0;
  logic       hyp_is64 = 1'b0;
  logic [2:0] trap_ctl = '0;
  logic       res_vld;
  logic [2:0] res_code;
  logic [7:0] res_syn;
  logic [1:0] res_regime;
  logic [1:0] res_cause;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int e_vld, e_code, e_syn, e_reg, e_cause;
  string e_tag;

  always #4 clk = ~clk;

  cp_maint_gatekeeper u0 (
    .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb),
    .cp_num(cp_num), .op_hi(op_hi), .cr_major(cr_major),
    .cr_minor(cr_minor), .op_lo(op_lo), .cur_level(cur_level),
    .feat_k32(feat_k32), .hyp_on(hyp_on), .hyp_is64(hyp_is64),
    .trap_ctl(trap_ctl), .res_vld(res_vld), .res_code(res_code),
    .res_syn(res_syn), .res_regime(res_regime), .res_cause(res_cause)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural model of the next verdict, from the requirements.
  task automatic predict();
    bit match;
    match = (cp_num == 4'd15) && (op_hi == 3'd0) && (cr_major == 4'd8) &&
            (cr_minor == 4'd3) && (op_lo == 3'd5);
    e_vld = dec_stb; e_code = 0; e_syn = 0; e_reg = 0; e_cause = 0; e_tag = "R8";
    if (!dec_stb) return;
    if (!match) begin e_tag = "R1"; return; end
    if (!feat_k32) begin e_code = 1; e_tag = "R2"; return; end
    case (cur_level)
      2'd0: begin e_code = 1; e_tag = "R3"; end
      2'd1: begin
        if (hyp_on && trap_ctl != 3'b000) begin
          e_code = hyp_is64 ? 2 : 3;
          e_syn  = 8'h03;
          e_cause = trap_ctl[0] ? 1 : (trap_ctl[1] ? 2 : 3);
          e_tag = "R5";
        end else begin
          e_code = 4; e_reg = 1; e_tag = "R6";
        end
      end
      2'd2: begin e_code = 4; e_reg = 1; e_tag = "R7"; end
      default: begin e_code = 4; e_reg = 2; e_tag = "R7"; end
    endcase
  endtask

  task automatic compare();
    chk("R8", "res_vld", int'(res_vld), e_vld);
    chk(e_tag, "res_code", int'(res_code), e_code);
    chk((e_tag == "R8") ? "R8" : "R5", "res_syn", int'(res_syn), e_syn);
    chk((e_tag == "R7" || e_tag == "R8") ? e_tag : "R6", "res_regime", int'(res_regime), e_reg);
    chk((e_tag == "R8") ? "R8" : "R4", "res_cause", int'(res_cause), e_cause);
  endtask

  task automatic set_match();
    cp_num = 4'd15; op_hi = 3'd0; cr_major = 4'd8; cr_minor = 4'd3; op_lo = 3'd5;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    e_vld = 0; e_code = 0; e_syn = 0; e_reg = 0; e_cause = 0; e_tag = "R8";
    repeat (3) @(negedge clk);
    compare();                    // reset state, R8
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // Directed sweep: every level, trap pattern and hypervisor state (R2..R7)
    for (int f = 0; f < 2; f++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int t = 0; t < 8; t++) begin
          for (int h = 0; h < 4; h++) begin
            set_match();
            feat_k32 = (f == 1); cur_level = 2'(lv); trap_ctl = 3'(t);
            hyp_on = h[0]; hyp_is64 = h[1]; dec_stb = 1'b1;
            predict();
            step();
          end
        end
      end
    end

    // Directed near-miss encodings (R1)
    for (int fld = 0; fld < 5; fld++) begin
      set_match(); feat_k32 = 1'b1; cur_level = 2'd2; dec_stb = 1'b1;
      case (fld)
        0: cp_num = 4'd14;
        1: op_hi = 3'd1;
        2: cr_major = 4'd7;
        3: cr_minor = 4'd7;
        default: op_lo = 3'd1;
      endcase
      predict();
      step();
    end

    // Idle gap then random traffic (R8 and all verdicts)
    dec_stb = 1'b0; predict(); step();
    for (int n = 0; n < 3000; n++) begin
      set_match();
      if (($urandom % 6) == 0) begin
        case ($urandom % 5)
          0: cp_num = 4'($urandom);
          1: op_hi = 3'($urandom);
          2: cr_major = 4'($urandom);
          3: cr_minor = 4'($urandom);
          default: op_lo = 3'($urandom);
        endcase
      end
      dec_stb   = (($urandom % 4) != 0);
      cur_level = 2'($urandom);
      feat_k32  = (($urandom % 10) != 0);
      hyp_on    = (($urandom % 10) < 7);
      hyp_is64  = 1'($urandom);
      trap_ctl  = 3'($urandom);
      predict();
      step();
    end

    dec_stb = 1'b0; predict(); step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule